// File: doc/BRIEF.md
# Lights Out Serial Toggle Engine

This block keeps an 8x8 game board in a 64-bit circular shift register. Cells are numbered row*8+col, and that number is also the bit index on `board_o`. Each clock of a calculation cycle moves every cell up by one place. The bit leaving cell 63 comes back into cell 0 through a feedback selector. A start strobe carries a 6-bit key coordinate and launches a fixed 128-clock cycle, which is two full turns. At the end of the cycle the board is back in its original alignment, with the Lights Out toggle pattern for that key applied.

No neighbour logic works on the board in parallel. A position counter holds the recirculating bit unchanged until the cells around the key are about to arrive at the feedback point. From that clock on, a 17-bit mask register shifts out one bit per clock, and each mask bit is XOR-ed into the returning bit. The mask holds a cross pattern normally, or a single centre bit in manual mode. Other logic can take over the feedback input to write a new board serially, for example random data or a saved pattern. It does this through an external-feedback select.

Top module: `lo_shift_engine`

## Requirements
- R1: After reset, `board_o` is all zeros and both `busy_o` and `done_o` are low.
- R2: A start strobe seen while idle raises `busy_o` from the next clock. `busy_o` then stays high for exactly 128 clocks. `done_o` is high for exactly the one clock after `busy_o` falls.
- R3: When `manual_i` is low at the strobe, the cycle inverts cells key-8, key-1, key, key+1 and key+8, each taken modulo 64, where key = row*8+col on `key_i`. Every other cell keeps its value.
- R4: The toggle is correct for every key value, including keys whose neighbours wrap modulo 64 (key 0, key 63) and key 55, which needs the longest stretch of unchanged shifting.
- R5: When `manual_i` is high at the strobe, only the cell at the key is inverted.
- R6: A start strobe that arrives while `busy_o` is high has no effect. The running cycle ends on its original schedule with the board result of the first key only.
- R7: While `fb_ext_i` is high during a cycle, the bit entering cell 0 on that shift is `fb_bit_i`. If `fb_ext_i` is high for a whole cycle, cell c ends up holding the `fb_bit_i` value supplied on shift 127-c, where shift 0 is the first clock after the strobe.
- R8: While idle, the board holds its value, and `fb_ext_i` and `fb_bit_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe for a calculation cycle |
| key_i | input | 6 | Key cell, row*8+col |
| manual_i | input | 1 | Single-cell toggle mode, sampled with the strobe |
| fb_ext_i | input | 1 | Select external feedback bit instead of rotation |
| fb_bit_i | input | 1 | External feedback bit |
| board_o | output | 64 | Board cells, bit index row*8+col |
| busy_o | output | 1 | Calculation cycle in progress |
| done_o | output | 1 | One-clock pulse after the cycle ends |

## Verification
The strobe is taken at edge E0. `busy_o` is due just after E0, and the 128 shifts happen on edges E1 to E128. `busy_o` falls and `done_o` rises just after E128, which is also when the final board is due. `done_o` is low again after E129. Inputs are driven and outputs sampled at falling edges, one falling edge per rising edge. The bench therefore checks `busy_o` after E0 and after E127, and checks the board and `done_o` after E128. External feedback bits are presented one falling edge ahead of the shift that consumes them.

// File: rtl/lo_pkg.sv
package lo_pkg;
  localparam int unsigned LO_ROW_W = 8;
  localparam int unsigned LO_CELLS = LO_ROW_W * LO_ROW_W;
  localparam int unsigned LO_KEY_W = $clog2(LO_CELLS);
  localparam int unsigned LO_MASK_LEN = 2 * LO_ROW_W + 1;
  localparam int unsigned LO_CYC_LEN = 2 * LO_CELLS;

  typedef logic [LO_CELLS-1:0] lo_board_t;
  typedef logic [LO_KEY_W-1:0] lo_key_t;
endpackage

// File: rtl/lo_cycle_ctl.sv
module lo_cycle_ctl #(
  parameter int unsigned CYC_LEN = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(CYC_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC_LEN - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic busy_q, busy_d, done_q, done_d, last;

  assign load_o = start_i & ~busy_q;
  assign last   = (cnt_q == LAST);

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (load_o) begin
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
      if (last) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R6: a strobe during a cycle must not restart the count
  assert_no_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  // R2: cycle ends with a done pulse and busy low
  assert_end_of_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && last) |=> (done_q && !busy_q));
endmodule

// File: rtl/lo_pos_counter.sv
module lo_pos_counter #(
  parameter int unsigned CELLS = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic                     step_i,
  input  logic [$clog2(CELLS)-1:0] start_i,
  output logic                     aligned_o
);
  localparam int unsigned KEY_W = $clog2(CELLS);

  logic [KEY_W:0] cnt_q, cnt_d;

  assign aligned_o = cnt_q[KEY_W];

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                  cnt_d = {1'b0, start_i};
    else if (step_i && !cnt_q[KEY_W]) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R4: once overflowed, the counter stays there until the next load
  assert_pos_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q[KEY_W] && !load_i) |=> cnt_q[KEY_W]);

  // R4: below overflow each shift advances the count by one
  assert_pos_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !cnt_q[KEY_W] && !load_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/lo_mask_reg.sv
module lo_mask_reg #(
  parameter int unsigned ROW_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic manual_i,
  input  logic adv_i,
  output logic bit_o,
  output logic empty_o
);
  localparam int unsigned MASK_LEN = 2 * ROW_W + 1;

  logic [MASK_LEN-1:0] pat, mask_q, mask_d;

  // bit 0 meets cell key+ROW_W, bit ROW_W meets the key, bit 2*ROW_W meets key-ROW_W
  for (genvar i = 0; i < MASK_LEN; i++) begin : g_pat
    if (i == ROW_W) begin : g_centre
      assign pat[i] = 1'b1;
    end else if (i == 0 || i == ROW_W - 1 || i == ROW_W + 1 || i == 2 * ROW_W) begin : g_arm
      assign pat[i] = ~manual_i;
    end else begin : g_off
      assign pat[i] = 1'b0;
    end
  end

  always_comb begin
    mask_d = mask_q;
    if (load_i)     mask_d = pat;
    else if (adv_i) mask_d = {1'b0, mask_q[MASK_LEN-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign bit_o   = mask_q[0];
  assign empty_o = (mask_q == '0);

  // R3: the mask fills with zeros as it advances
  assert_mask_zero_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> !mask_q[MASK_LEN-1]);

  // R5: manual load leaves exactly one bit set
  assert_manual_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && manual_i) |=> $onehot0(mask_q) && mask_q[ROW_W]);
endmodule

// File: rtl/lo_shift_engine.sv
module lo_shift_engine
  import lo_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [LO_KEY_W-1:0]    key_i,
  input  logic                   manual_i,
  input  logic                   fb_ext_i,
  input  logic                   fb_bit_i,
  output logic [LO_CELLS-1:0]    board_o,
  output logic                   busy_o,
  output logic                   done_o
);
  localparam lo_key_t LEAD = LO_KEY_W'(LO_ROW_W + 1);

  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       load, busy, aligned, mask_bit, mask_empty, fb;
  lo_key_t    start_val;
  lo_board_t  board_q, board_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  // count from key+ROW_W+1 so the mask front meets cell key+ROW_W
  assign start_val = key_i + LEAD;

  lo_cycle_ctl #(.CYC_LEN(LO_CYC_LEN)) u_ctl (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .start_i(start_i),
    .load_o (load),
    .busy_o (busy),
    .done_o (done_o)
  );

  lo_pos_counter #(.CELLS(LO_CELLS)) u_pos (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .load_i   (load),
    .step_i   (busy),
    .start_i  (start_val),
    .aligned_o(aligned)
  );

  lo_mask_reg #(.ROW_W(LO_ROW_W)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .load_i  (load),
    .manual_i(manual_i),
    .adv_i   (busy & aligned),
    .bit_o   (mask_bit),
    .empty_o (mask_empty)
  );

  assign fb = fb_ext_i ? fb_bit_i : (board_q[LO_CELLS-1] ^ (aligned & mask_bit));

  always_comb begin
    board_d = board_q;
    if (busy) board_d = {board_q[LO_CELLS-2:0], fb};
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) board_q <= '0;
    else        board_q <= board_d;
  end

  assign board_o = board_q;
  assign busy_o  = busy;

  // R2: done lasts one clock
  assert_done_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3: whole mask consumed by the end of a cycle
  assert_mask_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> mask_empty);

  // R8: idle board holds
  assert_board_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy && !start_i) |=> $stable(board_q));
endmodule

// File: tb/sim_lo_shift_engine.sv
module sim_lo_shift_engine;
  localparam int PERIOD = 10;
  localparam int NVEC = 8;
  // {initial board, key, manual}
  localparam logic [70:0] VEC [0:NVEC-1] = '{
    {64'h0000_0000_0000_0000, 6'd27, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFF, 6'd0,  1'b0},
    {64'h0123_4567_89AB_CDEF, 6'd63, 1'b0},
    {64'hA5A5_5A5A_0F0F_F0F0, 6'd55, 1'b0},
    {64'h8000_0000_0000_0001, 6'd54, 1'b0},
    {64'h0000_0000_0000_0000, 6'd18, 1'b1},
    {64'hDEAD_BEEF_CAFE_F00D, 6'd9,  1'b1},
    {64'h1357_9BDF_2468_ACE0, 6'd36, 1'b0}
  };

  logic        clk, rst_n, start, manual, fb_ext, fb_bit;
  logic [5:0]  key;
  logic [63:0] board;
  logic        busy, done;
  int checks = 0, fails = 0;
  bit finished = 0;

  lo_shift_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .key_i(key),
    .manual_i(manual), .fb_ext_i(fb_ext), .fb_bit_i(fb_bit),
    .board_o(board), .busy_o(busy), .done_o(done)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] toggled(input logic [63:0] b, input int k, input bit man);
    logic [63:0] r = b;
    r[k] = ~r[k];
    if (!man) begin
      r[(k + 1) % 64]  = ~r[(k + 1) % 64];
      r[(k + 63) % 64] = ~r[(k + 63) % 64];
      r[(k + 8) % 64]  = ~r[(k + 8) % 64];
      r[(k + 56) % 64] = ~r[(k + 56) % 64];
    end
    return r;
  endfunction

  // write a board through external feedback (R7)
  task automatic load_board(input logic [63:0] v);
    @(negedge clk);
    start = 1'b1; key = 6'd0; manual = 1'b0; fb_ext = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 128; t++) begin
      fb_ext = 1'b1;
      fb_bit = (t >= 64) ? v[127 - t] : 1'b1;
      @(negedge clk);
    end
    fb_ext = 1'b0; fb_bit = 1'b0;
    chk("R7 external load", board, v);
  endtask

  // one press; optionally a second strobe mid-cycle (R6)
  task automatic press(input logic [5:0] k, input bit man, input bit inject);
    @(negedge clk);
    start = 1'b1; key = k; manual = man;
    @(negedge clk);
    start = 1'b0; manual = 1'b0;
    chk("R2 busy after strobe", 64'(busy), 64'd1);
    for (int i = 0; i < 127; i++) begin
      if (inject && i == 40) begin
        start = 1'b1; key = k ^ 6'd5; manual = ~man;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk("R2 busy at clock 127", 64'(busy), 64'd1);
    @(negedge clk);
    chk("R2 busy fall", 64'(busy), 64'd0);
    chk("R2 done pulse", 64'(done), 64'd1);
    @(negedge clk);
    chk("R2 done width", 64'(done), 64'd0);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] b, ref_b;
    rst_n = 1'b0; start = 1'b0; key = '0; manual = 1'b0; fb_ext = 1'b0; fb_bit = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset board", board, 64'd0);
    chk("R1 reset busy", 64'(busy), 64'd0);
    chk("R1 reset done", 64'(done), 64'd0);

    // vector table: R3 cross, R4 wrap/long lead, R5 manual
    for (int v = 0; v < NVEC; v++) begin
      b = VEC[v][70:7];
      load_board(b);
      press(VEC[v][6:1], VEC[v][0], 1'b0);
      chk(VEC[v][0] ? "R5 manual toggle" : "R3 R4 cross toggle",
          board, toggled(b, int'(VEC[v][6:1]), VEC[v][0]));
    end

    // R8: idle feedback inputs ignored
    b = 64'hC3C3_3C3C_9999_6666;
    load_board(b);
    for (int i = 0; i < 10; i++) begin
      fb_ext = 1'b1; fb_bit = i[0];
      @(negedge clk);
    end
    fb_ext = 1'b0;
    chk("R8 idle hold", board, b);
    chk("R8 no done while idle", 64'(done), 64'd0);

    // R6: strobe during cycle ignored
    press(6'd28, 1'b0, 1'b1);
    ref_b = toggled(b, 28, 1'b0);
    chk("R6 mid-cycle strobe ignored", board, ref_b);

    // R3: same key twice restores
    press(6'd28, 1'b0, 1'b0);
    chk("R3 second press restores", board, b);

    // R4: corner key 7 manual then cross
    press(6'd7, 1'b1, 1'b0);
    chk("R5 manual corner", board, toggled(b, 7, 1'b1));
    press(6'd7, 1'b0, 1'b0);
    chk("R4 cross corner", board, toggled(toggled(b, 7, 1'b1), 7, 1'b0));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule